// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port on an APB-style peripheral bus. It holds an output data register and a direction register. It drives an output-data vector and an output-enable vector toward the pad ring. It also samples the pad inputs through a two-stage synchronizer. The synchronized inputs are brought out so that a separate detection block can use them. Pad cells, tri-state buffers, bus bridging and interrupt logic are outside this block.

The data register is reached through a window of addresses rather than a single address. Byte address bits [9:2] form a per-line mask, and mask bit n is address bit n+2. A write changes only the lines whose mask bit is set, so software can set or clear one pin with a single store and no read-modify-write. A read returns zero for every line whose mask bit is clear. Lines in input mode ignore data writes, so software selects output mode first and then writes the value. After reset every pin is an input.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the direction register and the data register both read 0x00, and gpio_oe and gpio_out are both 0x00.
- R2: The direction register sits at byte offset 0x400 and reads back what was written. Bit n set to 1 makes line n an output, and gpio_oe equals the register.
- R3: A write to byte offset A with A[11:10]=0 and A[1:0]=0 is a data write. Its mask is A[9:2], with mask bit n at address bit n+2. Data bit n takes pwdata[n] only when mask bit n is set and line n is an output. All other bits keep their value, and gpio_out shows the data register.
- R4: A data write leaves the data bit of every line in input mode unchanged, even when its mask bit is set.
- R5: On a data read, every line whose mask bit is clear returns 0.
- R6: On a data read, a line whose mask bit is set returns the data register bit when it is an output and the synchronized pad value when it is an input.
- R7: A change on gpio_in shows on gpio_sync after the second rising clock edge, not after the first.
- R8: An access to any other offset is unmapped. This covers offsets above the data window other than 0x400, and any offset with A[1:0] not zero. An unmapped read returns 0x00, and an unmapped write changes neither register.
- R9: pready is 1 in every cycle, so every transfer finishes in its access phase with no wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while psel is high and pwrite is low |
| pready | output | 1 | Transfer complete, always 1 |
| gpio_in | input | 8 | Raw pad inputs |
| gpio_out | output | 8 | Output data per line |
| gpio_oe | output | 8 | Output enable per line, 1 = drive |
| gpio_sync | output | 8 | Pad inputs after two synchronizer stages |

## Verification
Register writes take effect on the rising edge that ends the access phase, so gpio_out and gpio_oe are sampled on the falling edge that follows. Read data is combinational from the registers, so it is sampled in the access phase before that edge. A pad change is driven on a falling edge. gpio_sync is then sampled once after the first rising edge, where it must still hold the old value, and once after the second rising edge, where it must show the new value. Every observation is pushed with its expected value into the scoreboard in the same cycle, so each check compares against the result due in that exact cycle.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Holds the types shared by the GPIO port modules: the decoded
// address region of a bus transfer.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_DIR  = 2'd2
    } gpio_region_e;

endpackage

// File: rtl/gpio_sync2.sv
// Module gpio_sync2
// A two-flop synchronizer, one per pad line. A pad value shows on
// sync_o after the second rising edge.
// Assumes: pad inputs are quasi-static compared with the clock.
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_line
        // Purpose: two-stage capture of one pad line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[gi] <= 1'b0;
                stage2_q[gi] <= 1'b0;
            end else begin
                stage1_q[gi] <= pad_i[gi];
                stage2_q[gi] <= stage1_q[gi];
            end
        end
    end

    assign sync_o = stage2_q;

    // Cycles since reset (saturating), so the delay check only looks
    // at history that lies after reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_o == $past(pad_i, 2)));

endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module gpio_ctrl_regs
// Holds the output data register and the direction register. A data
// write updates only the lines that are both selected by the address
// mask and in output mode.
// Assumes: wr_en is a single-cycle strobe from the bus access phase.
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_region_e     region,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);

    logic             wr_data;
    logic             wr_dir;
    logic [WIDTH-1:0] upd;

    assign wr_data = wr_en && (region == RGN_DATA);
    assign wr_dir  = wr_en && (region == RGN_DIR);
    assign upd     = mask & dir_q;

    // Purpose: direction register, written whole at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        // Purpose: one data bit, updated when selected and driven.
        always_ff @(posedge clk) begin
            if (!rst_n)                     data_q[gi] <= 1'b0;
            else if (wr_data && upd[gi])    data_q[gi] <= wdata[gi];
        end
    end

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(data_q));

    assert_input_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_read_mux.sv
// Module gpio_read_mux
// Forms the read data for one transfer. Data reads return the
// per-line value gated by the address mask; direction reads return
// the direction register; unmapped reads return zero.
// Assumes: rd_en is high during the transfer being read.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  gpio_region_e     region,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] sync_i,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] line_val;

    // Purpose: choose driven value or sampled pad per line.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            line_val[i] = dir_q[i] ? data_q[i] : sync_i[i];
        end
    end

    // Purpose: select the read source by region.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (region)
                RGN_DATA: rdata = line_val & mask;
                RGN_DIR:  rdata = dir_q;
                default:  rdata = '0;
            endcase
        end
    end

    assert_masked_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_DATA) |-> ((rdata & ~mask) == '0));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_NONE) |-> (rdata == '0));

endmodule

// File: rtl/gpio_masked_port.sv
// Module gpio_masked_port
// Top level of the address-masked GPIO port. Decodes the bus address
// into a region and a line mask, and ties the registers, the read
// multiplexer and the input synchronizer together.
// Assumes: ADDR_W > WIDTH + 2 and the direction offset lies above the
// data window; transfers follow the setup/access phase protocol.
module gpio_masked_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH   = 8,
    parameter int               ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] DIR_OFS = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [WIDTH-1:0]  pwdata,
    output logic [WIDTH-1:0]  prdata,
    output logic              pready,
    input  logic [WIDTH-1:0]  gpio_in,
    output logic [WIDTH-1:0]  gpio_out,
    output logic [WIDTH-1:0]  gpio_oe,
    output logic [WIDTH-1:0]  gpio_sync
);

    localparam int MASK_LO = 2;
    localparam int MASK_HI = WIDTH + MASK_LO - 1;

    gpio_region_e     region;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic             wr_en;
    logic             rd_en;

    assign mask  = paddr[MASK_HI:MASK_LO];
    assign wr_en = psel && penable && pwrite;
    assign rd_en = psel && !pwrite;

    // Purpose: map the byte address onto a register region.
    always_comb begin
        if (paddr[MASK_LO-1:0] != '0)
            region = RGN_NONE;
        else if (paddr[ADDR_W-1:MASK_HI+1] == '0)
            region = RGN_DATA;
        else if (paddr == DIR_OFS)
            region = RGN_DIR;
        else
            region = RGN_NONE;
    end

    gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .region (region),
        .mask   (mask),
        .wdata  (pwdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (gpio_in),
        .sync_o (gpio_sync)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .region (region),
        .mask   (mask),
        .data_q (data_q),
        .dir_q  (dir_q),
        .sync_i (gpio_sync),
        .rdata  (prdata)
    );

    assign pready   = 1'b1;
    assign gpio_out = data_q;
    assign gpio_oe  = dir_q;

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && paddr == DIR_OFS) |=> (gpio_oe == $past(pwdata)));

endmodule

// File: tb/gpio_masked_port_tb.sv
module gpio_masked_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic        pready;
    logic [7:0]  gpio_in = '0;
    logic [7:0]  gpio_out;
    logic [7:0]  gpio_oe;
    logic [7:0]  gpio_sync;

    always #2 clk = ~clk;

    gpio_masked_port u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .gpio_sync(gpio_sync)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } sb_item_t;

    sb_item_t   exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    // Monitor: pops the expected item for each observed result.
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: result with no expectation actual=%h expected=none", obs_val);
            end else begin
                sb_item_t it;
                it = exp_q.pop_front();
                total++;
                if (obs_val !== it.val) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, obs_val, it.val);
                end
            end
        end
    end

    task automatic observe(input string tag, input logic [7:0] act, input logic [7:0] exp);
        sb_item_t it;
        it.tag = tag;
        it.val = exp;
        exp_q.push_back(it);
        obs_val = act;
        -> obs_ev;
        #0.1;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #0.5;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #0.5;
        observe(tag, prdata, exp);
        observe("R9 pready in access phase", {7'd0, pready}, 8'h01);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #0.5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state
        observe("R1 gpio_oe after reset", gpio_oe, 8'h00);
        observe("R1 gpio_out after reset", gpio_out, 8'h00);
        bus_read(12'h400, 8'h00, "R1 direction after reset");
        bus_read(12'h3FC, 8'h00, "R1 data after reset");

        // R4: all lines are inputs, a full-mask write changes nothing
        bus_write(12'h3FC, 8'hFF);
        observe("R4 gpio_out after write to inputs", gpio_out, 8'h00);

        // R6: input lines read synchronized pads
        gpio_in = 8'hA5;
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, 8'hA5, "R6 input lines read pads");

        // R2: direction register
        bus_write(12'h400, 8'h0F);
        observe("R2 gpio_oe follows direction", gpio_oe, 8'h0F);
        bus_read(12'h400, 8'h0F, "R2 direction readback");

        // R3/R4: full-mask write affects only output lines
        bus_write(12'h3FC, 8'hFF);
        observe("R3 gpio_out after full-mask write", gpio_out, 8'h0F);

        // R3: mask 0x03 (address 0x00C) clears lines 0 and 1 only
        bus_write(12'h00C, 8'h00);
        observe("R3 masked write lines 0-1", gpio_out, 8'h0C);

        // R3: mask 0x08 (address 0x020) writes line 3 from pwdata[3]
        bus_write(12'h020, 8'hF7);
        observe("R3 single line write", gpio_out, 8'h04);

        // R5/R6: masked reads
        bus_read(12'h030, 8'h04, "R5 mask 0x0C read of outputs");
        bus_read(12'h3C0, 8'hA0, "R6 mask 0xF0 read of inputs");
        bus_read(12'h004, 8'h00, "R5 mask 0x01 read of cleared output");
        bus_read(12'h000, 8'h00, "R5 empty mask reads zero");

        // R8: unmapped offsets
        bus_write(12'h404, 8'hFF);
        bus_write(12'h800, 8'hFF);
        bus_write(12'h3FD, 8'hFF);
        observe("R8 gpio_out after unmapped writes", gpio_out, 8'h04);
        bus_read(12'h400, 8'h0F, "R8 direction after unmapped writes");
        bus_read(12'h404, 8'h00, "R8 unmapped read 0x404");
        bus_read(12'h800, 8'h00, "R8 unmapped read 0x800");
        bus_read(12'h3FD, 8'h00, "R8 misaligned read");

        // R7: two-stage synchronizer timing
        @(negedge clk);
        gpio_in = 8'h3C;
        @(negedge clk);
        #0.5;
        observe("R7 sync after one edge", gpio_sync, 8'hA5);
        @(negedge clk);
        #0.5;
        observe("R7 sync after two edges", gpio_sync, 8'h3C);

        // R2/R4: turn all lines to inputs, data writes locked out
        bus_write(12'h400, 8'h00);
        observe("R2 gpio_oe cleared", gpio_oe, 8'h00);
        bus_write(12'h3FC, 8'hFF);
        observe("R4 input data locked", gpio_out, 8'h04);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: leftover actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule